// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This unit takes one request to move a group of registers to or from memory and turns it into a series of single-word accesses, one per clock cycle. A request consists of a base address, a 16-bit mask that selects the registers, a two-bit addressing mode, a load/store flag and a writeback enable. It is presented together with a one-cycle start pulse. The sequencer counts the selected registers and works out the lowest address of the block from the mode and that count. It then walks the selected registers from the lowest index upward, with each address 4 bytes above the one before.

After the last access the unit raises a single-cycle done strobe. When writeback was requested, it also presents the moved base value in that same cycle. The memory and the register file sit outside the block. The caller uses the access strobe, address, register index and direction to perform each transfer. Pairing modes gives the usual stack disciplines. A descending full stack pushes with decrement-before and pops with increment-after. An ascending empty stack pushes with increment-after and pops with decrement-before.

Top module: `blkxfer_seq`

## Requirements
- R1: Mode encoding is 0 = increment-after and 1 = increment-before. The first access address is the base for mode 0 and base + 4 for mode 1.
- R2: Mode encoding is 2 = decrement-after and 3 = decrement-before. With n selected registers, the first access address is base − 4·n + 4 for mode 2 and base − 4·n for mode 3 (modulo 2^32).
- R3: Accesses come out on consecutive cycles in ascending register index (mask bit i selects register i). Each address is 4 above the previous one, so the lowest index always sits at the lowest address.
- R4: There is exactly one access per set mask bit and none for a clear bit. The access direction output equals the load/store flag that was captured at start (1 = load).
- R5: The first access appears in the cycle after the start pulse is sampled. Done is high for exactly one cycle, in the cycle after the last access.
- R6: The writeback-valid output is high only in the done cycle, and only when writeback was enabled at start. The writeback value is then base + 4·n for modes 0 and 1, and base − 4·n for modes 2 and 3.
- R7: An empty mask makes no access. Done is raised in the cycle after start, and the writeback value equals the unchanged base.
- R8: A start pulse is only accepted while idle. A pulse during an access or in the done cycle has no effect on the running sequence and starts nothing afterwards.
- R9: While reset is asserted, and after it, no access, done or writeback strobe is raised until a start arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, sampled while idle |
| base_i | input | 32 | Base address |
| mask_i | input | 16 | Register selection mask |
| mode_i | input | 2 | Addressing mode (0 IA, 1 IB, 2 DA, 3 DB) |
| wb_en_i | input | 1 | Writeback enable |
| load_i | input | 1 | 1 = load, 0 = store |
| acc_valid_o | output | 1 | One word access this cycle |
| acc_addr_o | output | 32 | Word address of the access |
| acc_reg_o | output | 4 | Register index of the access |
| acc_load_o | output | 1 | Direction of the access |
| done_o | output | 1 | Transfer finished (one cycle) |
| wb_valid_o | output | 1 | Writeback value presented |
| wb_base_o | output | 32 | Updated base value |

## Verification
The checker assumes that start is only raised once the internal reset has been released. The bench waits several cycles after releasing reset before it sends a request. The checker also treats any start seen while idle as a real request, so its occupancy tracking follows the ports alone. The bench drives all inputs at the falling edge and drops start after one cycle. Its only starts outside idle are deliberate stray pulses sent in the first busy or done cycle, and these must be ignored. Mixed random requests, including wrapping bases, come from a fixed seed, alongside directed corner masks and a push/pop pair through a modelled memory.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  typedef enum logic [1:0] {
    XM_INC_AFTER  = 2'd0,
    XM_INC_BEFORE = 2'd1,
    XM_DEC_AFTER  = 2'd2,
    XM_DEC_BEFORE = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_FIN  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/blkxfer_rstsync.sv
module blkxfer_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/blkxfer_popcnt.sv
module blkxfer_popcnt #(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) begin
      cnt_o = cnt_o + CW'(vec_i[i]);
    end
  end

endmodule

// File: rtl/blkxfer_plan.sv
module blkxfer_plan
  import blkxfer_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 5,
  parameter int STEP = 4
) (
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [1:0]    mode_i,
  output logic [AW-1:0] first_o,
  output logic [AW-1:0] final_o
);

  localparam logic [AW-1:0] STEP_W = AW'(STEP);

  logic [AW-1:0] span;
  logic [AW-1:0] low_end;
  logic [AW-1:0] high_end;

  assign span     = AW'(cnt_i) * STEP_W;
  assign low_end  = base_i - span;
  assign high_end = base_i + span;

  always_comb begin
    unique case (xfer_mode_e'(mode_i))
      XM_INC_AFTER:  first_o = base_i;
      XM_INC_BEFORE: first_o = base_i + STEP_W;
      XM_DEC_AFTER:  first_o = low_end + STEP_W;
      default:       first_o = low_end;
    endcase
  end

  assign final_o = mode_i[1] ? low_end : high_end;

endmodule

// File: rtl/blkxfer_pick.sv
module blkxfer_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  onehot_o,
  output logic          last_o
);

  logic found;

  always_comb begin
    idx_o = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (vec_i[i] && !found) begin
        idx_o = IW'(i);
        found = 1'b1;
      end
    end
  end

  assign onehot_o = vec_i & (~vec_i + N'(1));
  assign last_o   = ((vec_i & (vec_i - N'(1))) == '0);

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NREG = 16,
  parameter int STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [AW-1:0]   base_i,
  input  logic [NREG-1:0] mask_i,
  input  logic [1:0]      mode_i,
  input  logic            wb_en_i,
  input  logic            load_i,
  output logic            acc_valid_o,
  output logic [AW-1:0]   acc_addr_o,
  output logic [$clog2(NREG)-1:0] acc_reg_o,
  output logic            acc_load_o,
  output logic            done_o,
  output logic            wb_valid_o,
  output logic [AW-1:0]   wb_base_o
);

  localparam int IW = $clog2(NREG);
  localparam int CW = $clog2(NREG + 1);
  localparam logic [AW-1:0] STEP_W = AW'(STEP);

  logic rst_sync_n;

  seq_state_e      state_q, state_n;
  logic [NREG-1:0] pend_q, pend_n;
  logic [AW-1:0]   addr_q, addr_n;
  logic [AW-1:0]   wbval_q, wbval_n;
  logic            load_q, load_n;
  logic            wben_q, wben_n;

  logic [CW-1:0]   req_cnt;
  logic [AW-1:0]   req_first;
  logic [AW-1:0]   req_final;
  logic [IW-1:0]   cur_idx;
  logic [NREG-1:0] cur_onehot;
  logic            cur_last;
  logic            accept;
  logic            advance;

  blkxfer_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  blkxfer_popcnt #(.N(NREG), .CW(CW)) u_cnt (
    .vec_i (mask_i),
    .cnt_o (req_cnt)
  );

  blkxfer_plan #(.AW(AW), .CW(CW), .STEP(STEP)) u_plan (
    .base_i  (base_i),
    .cnt_i   (req_cnt),
    .mode_i  (mode_i),
    .first_o (req_first),
    .final_o (req_final)
  );

  blkxfer_pick #(.N(NREG), .IW(IW)) u_pick (
    .vec_i    (pend_q),
    .idx_o    (cur_idx),
    .onehot_o (cur_onehot),
    .last_o   (cur_last)
  );

  assign accept  = (state_q == SQ_IDLE) && start_i;
  assign advance = (state_q == SQ_RUN);

  always_comb begin
    state_n = state_q;
    pend_n  = pend_q;
    addr_n  = addr_q;
    wbval_n = wbval_q;
    load_n  = load_q;
    wben_n  = wben_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (accept) begin
          pend_n  = mask_i;
          addr_n  = req_first;
          wbval_n = req_final;
          load_n  = load_i;
          wben_n  = wb_en_i;
          state_n = (mask_i == '0) ? SQ_FIN : SQ_RUN;
        end
      end
      SQ_RUN: begin
        pend_n = pend_q & ~cur_onehot;
        addr_n = addr_q + STEP_W;
        if (cur_last) begin
          state_n = SQ_FIN;
        end
      end
      default: begin
        state_n = SQ_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= SQ_IDLE;
    end else begin
      state_q <= state_n;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pend_q  <= '0;
      addr_q  <= '0;
      wbval_q <= '0;
      load_q  <= 1'b0;
      wben_q  <= 1'b0;
    end else if (accept || advance) begin
      pend_q  <= pend_n;
      addr_q  <= addr_n;
      wbval_q <= wbval_n;
      load_q  <= load_n;
      wben_q  <= wben_n;
    end
  end

  assign acc_valid_o = (state_q == SQ_RUN);
  assign acc_addr_o  = addr_q;
  assign acc_reg_o   = cur_idx;
  assign acc_load_o  = load_q;
  assign done_o      = (state_q == SQ_FIN);
  assign wb_valid_o  = done_o && wben_q;
  assign wb_base_o   = wb_valid_o ? wbval_q : '0;

endmodule

// File: rtl/blkxfer_seq_chk.sv
module blkxfer_seq_chk #(
  parameter int AW   = 32,
  parameter int NREG = 16,
  parameter int STEP = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [NREG-1:0] mask_i,
  input logic            wb_en_i,
  input logic            acc_valid_o,
  input logic [AW-1:0]   acc_addr_o,
  input logic [$clog2(NREG)-1:0] acc_reg_o,
  input logic            acc_load_o,
  input logic            done_o,
  input logic            wb_valid_o
);

  logic busy_c;
  logic wb_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_c <= 1'b0;
      wb_c   <= 1'b0;
    end else if (start_i && !busy_c) begin
      busy_c <= 1'b1;
      wb_c   <= wb_en_i;
    end else if (done_o) begin
      busy_c <= 1'b0;
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_o && $past(acc_valid_o) |-> acc_addr_o == $past(acc_addr_o) + AW'(STEP)); // R3
  AST_REG_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_o && $past(acc_valid_o) |-> acc_reg_o > $past(acc_reg_o)); // R3
  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_o && $past(acc_valid_o) |-> $stable(acc_load_o)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R5
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acc_valid_o) |-> done_o); // R5
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && acc_valid_o)); // R5
  AST_WB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> wb_valid_o == wb_c); // R6
  AST_WB_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> done_o); // R6
  AST_EMPTY_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_c && mask_i == '0 |=> done_o && !acc_valid_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_c |-> !acc_valid_o && !done_o); // R8
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_c |=> acc_valid_o || done_o); // R5

endmodule

bind blkxfer_seq blkxfer_seq_chk #(.AW(AW), .NREG(NREG), .STEP(STEP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .start_i     (start_i),
  .mask_i      (mask_i),
  .wb_en_i     (wb_en_i),
  .acc_valid_o (acc_valid_o),
  .acc_addr_o  (acc_addr_o),
  .acc_reg_o   (acc_reg_o),
  .acc_load_o  (acc_load_o),
  .done_o      (done_o),
  .wb_valid_o  (wb_valid_o)
);

// File: tb/blkxfer_seq_bench.sv
module blkxfer_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] base_i;
  logic [15:0] mask_i;
  logic [1:0]  mode_i;
  logic        wb_en_i;
  logic        load_i;
  logic        acc_valid_o;
  logic [31:0] acc_addr_o;
  logic [3:0]  acc_reg_o;
  logic        acc_load_o;
  logic        done_o;
  logic        wb_valid_o;
  logic [31:0] wb_base_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [0:255];
  logic [31:0] rf  [0:15];

  always #2.5 clk = ~clk;

  blkxfer_seq u_blkxfer_seq (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .base_i (base_i),
    .mask_i (mask_i), .mode_i (mode_i), .wb_en_i (wb_en_i), .load_i (load_i),
    .acc_valid_o (acc_valid_o), .acc_addr_o (acc_addr_o), .acc_reg_o (acc_reg_o),
    .acc_load_o (acc_load_o), .done_o (done_o), .wb_valid_o (wb_valid_o),
    .wb_base_o (wb_base_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic int pc(input logic [15:0] m);
    int n = 0;
    for (int i = 0; i < 16; i++) n += int'(m[i]);
    return n;
  endfunction

  function automatic logic [31:0] exp_first(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md);
    logic [31:0] s = 32'(pc(m) * 4);
    case (md)
      2'd0: return b;
      2'd1: return b + 32'd4;
      2'd2: return b - s + 32'd4;
      default: return b - s;
    endcase
  endfunction

  function automatic logic [31:0] exp_wb(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md);
    logic [31:0] s = 32'(pc(m) * 4);
    return md[1] ? b - s : b + s;
  endfunction

  task automatic run_xfer(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md,
                          input logic wb, input logic ld, input bit poke, output logic [31:0] wbo);
    int n = pc(m);
    int seen = 0;
    logic [31:0] ea = exp_first(b, m, md);
    logic [15:0] rem = m;
    bit fin = 0;
    wbo = b;
    start_i = 1'b1; base_i = b; mask_i = m; mode_i = md; wb_en_i = wb; load_i = ld;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 40 && !fin; k++) begin
      if (acc_valid_o) begin
        logic [3:0] er = 4'd0;
        for (int i = 15; i >= 0; i--) if (rem[i]) er = 4'(i);
        if (seen == 0) chk(acc_addr_o == ea, md[1] ? "R2 first addr" : "R1 first addr", acc_addr_o, ea);
        else chk(acc_addr_o == ea, "R3 addr step", acc_addr_o, ea);
        chk(acc_reg_o == er && rem != 0, "R3 reg order", 32'(acc_reg_o), 32'(er));
        chk(acc_load_o == ld, "R4 direction", 32'(acc_load_o), 32'(ld));
        if (seen == 0) chk(k == 0, "R5 first access latency", k, 0);
        if (ld) rf[acc_reg_o] = mem[acc_addr_o[9:2]];
        else mem[acc_addr_o[9:2]] = rf[acc_reg_o];
        rem[er] = 1'b0;
        ea += 32'd4;
        seen++;
      end
      if (done_o) begin
        fin = 1;
        chk(seen == n, "R4 access count", seen, n);
        chk(wb_valid_o == wb, "R6 wb valid", 32'(wb_valid_o), 32'(wb));
        if (wb) begin
          chk(wb_base_o == exp_wb(b, m, md), m == 0 ? "R7 wb base" : "R6 wb base", wb_base_o, exp_wb(b, m, md));
          wbo = wb_base_o;
        end
        if (m == 0) chk(k == 0 && seen == 0, "R7 empty done", k, 0);
        else chk(k == n, "R5 done timing", k, n);
      end
      if (poke && k == 0) begin
        start_i = 1'b1; base_i = $urandom; mask_i = 16'($urandom); mode_i = 2'($urandom);
        wb_en_i = 1'b1; load_i = ~ld;
      end
      @(negedge clk);
      start_i = 1'b0;
    end
    if (!fin) chk(0, "R5 missing done", 0, 1);
    chk(!acc_valid_o && !done_o, "R8 idle after", 32'({acc_valid_o, done_o}), 0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w, w2;
    logic [31:0] saved [0:15];
    void'($urandom(32'd24681));
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    for (int i = 0; i < 16; i++) rf[i] = 32'(i * 10);
    rst_n = 1'b0; start_i = 1'b0; base_i = '0; mask_i = '0; mode_i = '0; wb_en_i = 1'b0; load_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!acc_valid_o && !done_o && !wb_valid_o, "R9 reset quiet", 32'({acc_valid_o, done_o, wb_valid_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!acc_valid_o && !done_o && !wb_valid_o, "R9 post-reset quiet", 32'({acc_valid_o, done_o, wb_valid_o}), 0);

    // R1 R2 directed: registers 1..3 at base 0x10
    run_xfer(32'h10, 16'h000E, 2'd0, 1'b1, 1'b1, 0, w);
    chk(w == 32'h1C, "R6 IA example", w, 32'h1C);
    run_xfer(32'h10, 16'h000E, 2'd3, 1'b1, 1'b1, 0, w);
    chk(w == 32'h04, "R6 DB example", w, 32'h04);
    run_xfer(32'h10, 16'h000E, 2'd1, 1'b1, 1'b0, 0, w);
    run_xfer(32'h10, 16'h000E, 2'd2, 1'b0, 1'b0, 0, w);
    run_xfer(32'h0, 16'hFFFF, 2'd2, 1'b1, 1'b0, 0, w);
    run_xfer(32'h4, 16'h8000, 2'd3, 1'b1, 1'b1, 0, w);
    run_xfer(32'hFFFF_FFF8, 16'h8001, 2'd1, 1'b1, 1'b0, 0, w);
    run_xfer(32'h1234_5678, 16'h0000, 2'd3, 1'b1, 1'b0, 0, w);
    run_xfer(32'h40, 16'h0000, 2'd0, 1'b0, 1'b1, 1, w);
    run_xfer(32'h80, 16'h00F0, 2'd0, 1'b1, 1'b0, 1, w);

    // push with decrement-before, pop with increment-after
    for (int i = 0; i < 16; i++) begin rf[i] = $urandom; saved[i] = rf[i]; end
    run_xfer(32'h300, 16'h4A3C, 2'd3, 1'b1, 1'b0, 0, w);
    for (int i = 0; i < 16; i++) rf[i] = 32'hDEAD_0000;
    run_xfer(w, 16'h4A3C, 2'd0, 1'b1, 1'b1, 0, w2);
    chk(w2 == 32'h300, "R6 push/pop base restore", w2, 32'h300);
    for (int i = 0; i < 16; i++)
      if (16'h4A3C & (16'h1 << i)) chk(rf[i] == saved[i], "R3 push/pop data", rf[i], saved[i]);

    for (int t = 0; t < 150; t++) begin
      logic [15:0] m = 16'($urandom);
      if (t % 11 == 0) m = 16'h0;
      if (t % 7 == 0) m = 16'h1 << ($urandom % 16);
      run_xfer($urandom, m, 2'($urandom), 1'($urandom), 1'($urandom), (t % 4 == 0), w);
      repeat ($urandom % 3) @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule